// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device-side command decoder of a small serial configuration flash model. A host drives an active-low select, a serial clock and a serial data-in line. The block samples these three lines in its own system clock domain. While select is low it collects an opcode byte and then any address or data bytes, most significant bit first, on rising serial clock edges.

A status request is answered at once on the serial data-out line. A command that changes state is only judged when select returns high. It is accepted if the transfer ended on a whole byte with the byte count the command needs, if writes were enabled beforehand, and if no earlier write or erase is still busy. An accepted command gives a one-cycle start pulse to the memory controller behind the block, with a command code, the captured address and one data byte. The controller pulses `mem_done` when the array work has finished, which clears the busy flag.

The status byte holds, from bit 7 down to bit 0: two reserved zeros, the bottom-protect flag, three protect-level bits, the write-enable latch and the busy flag.

Top module: `flash_cmd_frontend`

## Requirements
- R1: Bits on `spi_mosi` are taken on rising `spi_clk` edges while `spi_cs_n` is low, MSB first. The first byte is the opcode and the next three bytes form the address, high byte first, which appears on `cmd_addr` for a byte write (02h) or a sector erase (D8h).
- R2: After opcode 05h the status byte is driven on `spi_miso`, MSB first. Each bit changes on a falling `spi_clk` edge, and the first bit follows the falling edge after the eighth rising edge. The byte repeats for as long as select stays low, and it reads {0, 0, bottom-flag, level[2:0], write-enable, busy} from bit 7 to bit 0. It reads all zeros after reset.
- R3: `spi_miso_oe` is low while select is high, and during the opcode byte. It is high only while status bits are being driven.
- R4: Opcode 06h with no further bytes sets the write-enable bit (bit 1) when not busy.
- R5: A commit gives one `cmd_start` pulse, sets busy (bit 0) and clears write-enable. It needs write-enable set, busy clear and the exact byte count. The counts are: write-status 01h plus one data byte (code 3), byte write 02h plus three address bytes and at least one data byte (code 0), sector erase D8h plus three address bytes (code 1), bulk erase C7h alone (code 2). The code is given on `cmd_kind`.
- R6: If select rises when the bit count is not a multiple of 8, the command is dropped. No pulse is given and the status is unchanged.
- R7: A command whose byte count is wrong, including a missing address byte, is dropped. No pulse is given and the status is unchanged.
- R8: While busy, every command except the status read is dropped, write-enable included. The status read still works and shows busy. A `mem_done` pulse clears busy.
- R9: For a byte write, `cmd_data` carries the last complete data byte of the transfer.
- R10: An accepted write-status loads bits 5..2 of its data byte into the bottom flag and the level bits. Bits 7 and 6 always read as zero.
- R11: Bulk erase is dropped while any level bit is set. Write-enable stays set in that case.
- R12: Raising select part-way through a status byte ends the output at once. The next transfer starts again at bit 0 of a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data into the block |
| mem_done | input | 1 | One-cycle pulse from the controller when the array work has finished |
| spi_miso | output | 1 | Serial status data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |
| cmd_start | output | 1 | One-cycle pulse for an accepted command |
| cmd_kind | output | 2 | Code of the accepted command |
| cmd_addr | output | 8*ADDR_BYTES | Captured address |
| cmd_data | output | 8 | Captured data byte |

## Verification
The assertions take for granted that the three serial lines change slowly compared with `clk`: each level of the serial clock lasts at least the synchronizer depth plus two system clocks. They also assume that select never changes in the same sampled cycle as a serial clock edge, and that `mem_done` is pulsed only while a command is busy. The bench holds every serial clock level for four system clocks. It moves select only while the serial clock has been steady for several cycles, and it pulses `mem_done` only when its own model says the block is busy. Random command mixes, with varying byte counts, stray extra bits and protect settings, stay inside these limits.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SERA = 8'hD8;
  localparam logic [7:0] OP_BERA = 8'hC7;

  typedef enum logic [1:0] {
    K_PROG   = 2'd0,
    K_SERASE = 2'd1,
    K_BERASE = 2'd2,
    K_STWR   = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_rise,
  output logic din
);
  // vector layout: {cs_n, sclk, mosi}; idle value has select high
  localparam logic [2:0] IDLE = 3'b100;

  logic [2:0] cur;
  logic [2:0] last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [2:0] q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q <= IDLE;
          else     q <= {cs_n, sclk, mosi};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q <= IDLE;
          else     q <= g_stage[g-1].q;
        end
      end
    end
  endgenerate

  assign cur = g_stage[STAGES-1].q;

  always_ff @(posedge clk) begin
    if (rst) last <= IDLE;
    else     last <= cur;
  end

  assign cs_act    = ~cur[2];
  assign cs_rise   = cur[2] & ~last[2];
  assign sclk_rise = cur[1] & ~last[1] & ~cur[2];
  assign sclk_fall = ~cur[1] & last[1] & ~cur[2];
  assign din       = cur[0];
endmodule

// File: rtl/cmd_collector.sv
module cmd_collector
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int BCNT_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_act,
  input  logic                    bit_rise,
  input  logic                    din,
  output logic [2:0]              bit_cnt,
  output logic [BCNT_W-1:0]       byte_cnt,
  output logic [7:0]              opcode,
  output logic [8*ADDR_BYTES-1:0] addr,
  output logic [7:0]              data,
  output logic                    rd_mode
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam logic [BCNT_W-1:0] CNT_ONE   = BCNT_W'(1);
  localparam logic [BCNT_W-1:0] CNT_ALAST = BCNT_W'(ADDR_BYTES);
  localparam logic [BCNT_W-1:0] CNT_SAT   = BCNT_W'(ADDR_BYTES + 2);

  logic [6:0] sr;
  logic [7:0] byte_nxt;
  logic       byte_end;

  assign byte_nxt = {sr, din};
  assign byte_end = bit_rise && (bit_cnt == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; bit_cnt <= '0; byte_cnt <= '0;
      opcode <= '0; addr <= '0; data <= '0; rd_mode <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rd_mode  <= 1'b0;
    end else if (bit_rise) begin
      sr      <= byte_nxt[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (byte_end) begin
        if (byte_cnt != CNT_SAT) byte_cnt <= byte_cnt + CNT_ONE;
        if (byte_cnt == '0) begin
          opcode  <= byte_nxt;
          rd_mode <= (byte_nxt == OP_RDSR);
        end
        if (byte_cnt >= CNT_ONE && byte_cnt <= CNT_ALAST)
          addr <= {addr[ADDR_W-9:0], byte_nxt};
        if ((opcode == OP_WRSR && byte_cnt == CNT_ONE) ||
            (opcode == OP_PROG && byte_cnt > CNT_ALAST))
          data <= byte_nxt;
      end
    end
  end

  // R1: byte count moves only on a serial rising edge
  a_r1_byte_step: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !bit_rise) |=> $stable(byte_cnt));
endmodule

// File: rtl/status_shifter.sv
module status_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_act,
  input  logic       bit_fall,
  input  logic       rd_mode,
  input  logic [7:0] status,
  output logic       miso,
  output logic       miso_oe
);
  logic [2:0] idx;
  logic [6:0] snap;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      miso <= 1'b0; miso_oe <= 1'b0; idx <= '0; snap <= '0;
    end else if (bit_fall && rd_mode) begin
      miso_oe <= 1'b1;
      idx     <= idx + 3'd1;
      if (idx == 3'd0) begin
        miso <= status[7];
        snap <= status[6:0];
      end else begin
        miso <= snap[6];
        snap <= {snap[5:0], 1'b0};
      end
    end
  end

  // R3: output is enabled only in the status-read phase
  a_r3_oe_only_read: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> rd_mode);
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_BYTES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    spi_clk,
  input  logic                    spi_cs_n,
  input  logic                    spi_mosi,
  input  logic                    mem_done,
  output logic                    spi_miso,
  output logic                    spi_miso_oe,
  output logic                    cmd_start,
  output logic [1:0]              cmd_kind,
  output logic [8*ADDR_BYTES-1:0] cmd_addr,
  output logic [7:0]              cmd_data
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int BCNT_W = $clog2(ADDR_BYTES + 3);
  localparam logic [BCNT_W-1:0] B_SINGLE = BCNT_W'(1);
  localparam logic [BCNT_W-1:0] B_STWR   = BCNT_W'(2);
  localparam logic [BCNT_W-1:0] B_SERA   = BCNT_W'(ADDR_BYTES + 1);
  localparam logic [BCNT_W-1:0] B_PROG   = BCNT_W'(ADDR_BYTES + 2);

  logic sclk_rise, sclk_fall, cs_act, cs_rise, din;
  logic [2:0]        bit_cnt;
  logic [BCNT_W-1:0] byte_cnt;
  logic [7:0]        opcode, data;
  logic [ADDR_W-1:0] addr;
  logic              rd_mode;

  logic       wel, wip, tb;
  logic [2:0] bp;
  logic [7:0] status;
  logic       go, wel_set;
  cmd_kind_e  go_kind;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(spi_clk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
    .cs_rise(cs_rise), .din(din)
  );

  cmd_collector #(.ADDR_BYTES(ADDR_BYTES), .BCNT_W(BCNT_W)) u_coll (
    .clk(clk), .rst(rst), .cs_act(cs_act), .bit_rise(sclk_rise), .din(din),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .opcode(opcode), .addr(addr),
    .data(data), .rd_mode(rd_mode)
  );

  assign status = {2'b00, tb, bp, wel, wip};

  status_shifter u_tx (
    .clk(clk), .rst(rst), .cs_act(cs_act), .bit_fall(sclk_fall),
    .rd_mode(rd_mode), .status(status), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  // Commit decision at the end of a transfer
  always_comb begin
    go      = 1'b0;
    wel_set = 1'b0;
    go_kind = K_PROG;
    if (cs_rise && bit_cnt == 3'd0 && !wip) begin
      case (opcode)
        OP_WREN: wel_set = (byte_cnt == B_SINGLE);
        OP_WRSR: begin go = wel && (byte_cnt == B_STWR); go_kind = K_STWR; end
        OP_PROG: begin go = wel && (byte_cnt == B_PROG); go_kind = K_PROG; end
        OP_SERA: begin go = wel && (byte_cnt == B_SERA); go_kind = K_SERASE; end
        OP_BERA: begin
          go      = wel && (byte_cnt == B_SINGLE) && (bp == 3'b000);
          go_kind = K_BERASE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0; wip <= 1'b0; tb <= 1'b0; bp <= '0;
      cmd_start <= 1'b0; cmd_kind <= '0; cmd_addr <= '0; cmd_data <= '0;
    end else begin
      cmd_start <= go;
      if (mem_done) wip <= 1'b0;
      if (go) begin
        cmd_kind <= go_kind;
        cmd_addr <= addr;
        cmd_data <= data;
        wel      <= 1'b0;
        wip      <= 1'b1;
        if (go_kind == K_STWR) begin
          tb <= data[5];
          bp <= data[4:2];
        end
      end else if (wel_set) begin
        wel <= 1'b1;
      end
    end
  end

  // R5: a start needs write-enable and leaves the block busy
  a_r5_needs_wel: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> $past(wel));
  a_r5_sets_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> (wip && !wel));
  // R6: starts only follow a select release
  a_r6_on_release: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> $past(cs_rise));
  // R8: nothing starts while busy, write-enable cannot rise while busy
  a_r8_busy_reject: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> !$past(wip));
  a_r8_wel_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> !$past(wip));
  // R11: bulk erase only with all level bits clear
  a_r11_bulk_unprot: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_kind == K_BERASE) |-> ($past(bp) == 3'b000));
  // R3: output released once select goes high
  a_r3_oe_release: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_miso_oe);
endmodule

// File: tb/flash_cmd_frontend_tb_top.sv
module flash_cmd_frontend_tb_top;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst, spi_clk, spi_cs_n, spi_mosi, mem_done;
  logic spi_miso, spi_miso_oe, cmd_start;
  logic [1:0]  cmd_kind;
  logic [23:0] cmd_addr;
  logic [7:0]  cmd_data;

  int n_checks = 0;
  int n_errors = 0;
  int n_starts = 0;
  logic [1:0]  last_kind;
  logic [23:0] last_addr;
  logic [7:0]  last_data;

  bit m_wel = 0, m_wip = 0, m_tb = 0;
  bit [2:0] m_bp = 0;

  always #5 clk = ~clk;

  flash_cmd_frontend dut_i (
    .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .mem_done(mem_done), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always @(negedge clk) begin
    if (cmd_start === 1'b1) begin
      n_starts++;
      last_kind = cmd_kind;
      last_addr = cmd_addr;
      last_data = cmd_data;
    end
  end

  function automatic logic [7:0] exp_status();
    return {2'b00, m_tb, m_bp, m_wel, m_wip};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    spi_mosi = b;
    wait_clk(HALF);
    spi_clk = 1'b1;
    wait_clk(HALF);
    spi_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic rd_status(output logic [7:0] b0, output logic [7:0] b1);
    logic [15:0] v;
    cs_low();
    chk("R3 oe low before opcode", spi_miso_oe, 1'b0);
    send_byte(8'h05);
    for (int i = 15; i >= 0; i--) begin
      wait_clk(HALF);
      v[i] = spi_miso;
      if (i == 15) chk("R3 oe high in read", spi_miso_oe, 1'b1);
      send_bit(1'b0);
    end
    cs_high();
    chk("R3 oe low after release", spi_miso_oe, 1'b0);
    b0 = v[15:8];
    b1 = v[7:0];
  endtask

  task automatic check_status(input string req);
    logic [7:0] b0, b1;
    rd_status(b0, b1);
    chk(req, b0, exp_status());
    chk("R2 status repeats", b1, exp_status());
  endtask

  task automatic pulse_done();
    @(negedge clk) mem_done = 1'b1;
    @(negedge clk) mem_done = 1'b0;
    m_wip = 0;
    wait_clk(2);
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [23:0] a,
                          input logic [7:0] d, input int nafter, input int extra);
    logic [7:0] b;
    cs_low();
    send_byte(op);
    for (int i = 0; i < nafter; i++) begin
      if (op == 8'h01)   b = d;
      else if (i < 3)    b = a[23 - 8*i -: 8];
      else               b = (i == nafter - 1) ? d : ~d;
      send_byte(b);
    end
    for (int i = 0; i < extra; i++) send_bit(1'($urandom));
    cs_high();
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d,
                        input int nafter, input int extra, input string req);
    int s0;
    bit ok, go;
    logic [1:0] k;
    s0 = n_starts;
    ok = (extra == 0) && !m_wip;
    go = 0;
    k  = 2'd0;
    case (op)
      8'h01: begin go = ok && m_wel && nafter == 1; k = 2'd3; end
      8'h02: begin go = ok && m_wel && nafter >= 4; k = 2'd0; end
      8'hD8: begin go = ok && m_wel && nafter == 3; k = 2'd1; end
      8'hC7: begin go = ok && m_wel && nafter == 0 && m_bp == 3'b000; k = 2'd2; end
      default: ;
    endcase
    send_cmd(op, a, d, nafter, extra);
    chk(req, n_starts - s0, go ? 1 : 0);
    if (go) begin
      chk("R5 command code", last_kind, k);
      if (op == 8'h02 || op == 8'hD8) chk("R1 address", last_addr, a);
      if (op == 8'h02) chk("R9 last data byte", last_data, d);
      if (op == 8'h01) chk("R10 status data", last_data, d);
      m_wel = 0;
      m_wip = 1;
      if (op == 8'h01) {m_tb, m_bp} = d[5:2];
    end else if (op == 8'h06 && ok && nafter == 0) begin
      m_wel = 1;
    end
    check_status(req);
  endtask

  initial begin
    logic [7:0] b0;
    logic [7:0] op;
    int r, na, ex;
    void'($urandom(32'd20240611));
    rst = 1'b1; spi_clk = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0; mem_done = 1'b0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);

    chk("R3 reset oe", spi_miso_oe, 1'b0);
    chk("R5 reset start", cmd_start, 1'b0);
    check_status("R2 reset status");

    do_cmd(8'h06, 24'h0, 8'h0, 0, 0, "R4 write enable");
    do_cmd(8'h02, 24'h123456, 8'hA5, 5, 0, "R5 byte write");
    do_cmd(8'h06, 24'h0, 8'h0, 0, 0, "R8 enable while busy");
    do_cmd(8'hD8, 24'h000100, 8'h0, 3, 0, "R8 erase while busy");
    pulse_done();
    check_status("R8 busy cleared");

    do_cmd(8'h06, 24'h0, 8'h0, 0, 0, "R4 write enable");
    do_cmd(8'hD8, 24'h0ABCDE, 8'h0, 3, 3, "R6 off boundary");
    do_cmd(8'hD8, 24'h0ABCDE, 8'h0, 2, 0, "R7 short address");
    do_cmd(8'hD8, 24'h0ABCDE, 8'h0, 3, 0, "R5 sector erase");
    pulse_done();

    do_cmd(8'h06, 24'h0, 8'h0, 0, 0, "R4 write enable");
    do_cmd(8'h01, 24'h0, 8'hFF, 1, 0, "R10 write status");
    pulse_done();
    do_cmd(8'h06, 24'h0, 8'h0, 0, 0, "R4 write enable");
    do_cmd(8'hC7, 24'h0, 8'h0, 0, 0, "R11 bulk protected");
    do_cmd(8'h01, 24'h0, 8'h00, 1, 0, "R10 clear levels");
    pulse_done();
    do_cmd(8'h06, 24'h0, 8'h0, 0, 0, "R4 write enable");
    do_cmd(8'hC7, 24'h0, 8'h0, 0, 0, "R5 bulk erase");
    pulse_done();

    // R12: release select part-way through a status byte
    cs_low();
    send_byte(8'h05);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    spi_clk = 1'b1;
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(HALF);
    spi_clk = 1'b0;
    wait_clk(8);
    chk("R12 oe off after early release", spi_miso_oe, 1'b0);
    do_cmd(8'h06, 24'h0, 8'h0, 0, 0, "R12 fresh opcode");

    for (int it = 0; it < 60; it++) begin
      r = $urandom % 7;
      case (r)
        0, 1, 2: op = 8'h06;
        3:       op = 8'h01;
        4:       op = 8'h02;
        5:       op = 8'hD8;
        default: op = 8'hC7;
      endcase
      if ($urandom % 4 != 0) begin
        case (op)
          8'h01:   na = 1;
          8'h02:   na = 4 + $urandom % 2;
          8'hD8:   na = 3;
          default: na = 0;
        endcase
      end else begin
        na = $urandom % 6;
      end
      ex = ($urandom % 6 == 0) ? 1 + $urandom % 7 : 0;
      do_cmd(op, 24'($urandom), 8'($urandom), na, ex, "R5 random command");
      if (m_wip && ($urandom % 2 == 0)) pulse_done();
    end

    rd_status(b0, b0);
    chk("R2 final status", b0, exp_status());

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule